// File: doc/BRIEF.md
# Circular Passing-Phase Window Selector

This block picks a sampling phase after a receive-clock tuning sweep. It takes a mask with one bit per sampling phase; a set bit means the tuning read at that phase passed. On a start strobe it captures the mask. It then walks the phases in ascending order, one phase per clock, and finds the runs of adjacent passing phases. The phase ring wraps, so a run that ends at the top phase and a separate run that begins at phase 0 are treated as one window.

The block takes the longest window. Inside that window it does not pick the centre. It picks the element at three quarters of the window length, biased one step toward the start. The result comes out as a single-cycle valid pulse with a phase index, or as a single-cycle error pulse when no phase passed. The phase output keeps its value between valid results, so it can drive a delay-line select directly.

Top module: `phase_window_sel`

## Requirements
- R1: After synchronous reset, `res_valid` and `res_err` are low and `sel_phase` is 0.
- R2: An all-zero mask gives a `res_err` pulse and no `res_valid` pulse.
- R3: Set mask bits at adjacent indices form one run. The run with the most bits is the chosen window.
- R4: When two or more windows have the greatest length, the one that comes first in ascending scan order wins.
- R5: If bit 0 and bit NPH-1 are both set but are not in the same run, the run ending at NPH-1 and the run starting at 0 join into one window. This window starts at the first index of the upper run. For tie-breaking it ranks at the position of the upper run, so the run at 0 stops being a candidate on its own.
- R6: An all-ones mask is one window 0..NPH-1 with no wrap join. For NPH=16 it selects phase 11.
- R7: For a chosen window of length L starting at index S, let k = floor(3L/4). If k is nonzero, subtract 1 from it. `sel_phase` = (S + k) mod NPH.
- R8: Exactly one of `res_valid` or `res_err` pulses high for one cycle. The pulse comes NPH+1 clock edges after the edge that accepts `start`.
- R9: While a selection is in progress, `start` and any change on `pass_mask` are ignored. The result uses the mask captured when `start` was accepted.
- R10: `sel_phase` changes only in the cycle where `res_valid` is high. It holds through error results and through new start strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection (accepted only when idle) |
| pass_mask | input | NPH | Pass flag per phase, bit i for phase i |
| sel_phase | output | $clog2(NPH) | Selected phase index, held between valid results |
| res_valid | output | 1 | One-cycle pulse: selection succeeded |
| res_err | output | 1 | One-cycle pulse: no passing phase |

## Verification
Two events can fall in the same scan step: the closing of the run that ends at the top phase, and its join with the run that started at phase 0. The bench provokes this with masks that set both end bits, including ties between the joined window and an inner run. It judges the result against an independent list-based model over a strided sweep of the whole mask space. The second overlap is a start strobe that is still high while a result is completing. The bench holds `start` high and changes the mask in mid-run. It then checks that the first result follows the captured mask, that the pulse still lasts one cycle, and that the next run is accepted only after the block is idle again.

// File: rtl/phsel_pkg.sv
package phsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } sel_state_t;
endpackage

// File: rtl/phsel_scan.sv
// Serial run tracker: one phase per step, keeps the best window seen so far.
module phsel_scan #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic [PW-1:0]  idx,
  input  logic [NPH-1:0] mask,
  input  logic           wrap,
  output logic [PW-1:0]  best_start,
  output logic [LW-1:0]  best_len
);
  logic [PW-1:0] cur_start;
  logic [LW-1:0] cur_len;
  logic [LW-1:0] lead_len;

  logic          bit_now, bit_nxt, close;
  logic [PW-1:0] run_start;
  logic [LW-1:0] run_len, cand_len;
  logic          is_lead, is_tail, take;

  always_comb begin
    bit_now   = mask[idx];
    bit_nxt   = (idx == PW'(NPH - 1)) ? 1'b0 : mask[idx + PW'(1)];
    close     = bit_now && !bit_nxt;
    run_start = (cur_len == '0) ? idx : cur_start;
    run_len   = cur_len + LW'(1);
    is_lead   = wrap && (run_start == '0);
    is_tail   = wrap && (idx == PW'(NPH - 1));
    cand_len  = is_tail ? (run_len + lead_len) : run_len;
    // the run at phase 0 is deferred: it only counts as part of the tail
    take      = close && !is_lead && (cand_len > best_len);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_start  <= '0;
      cur_len    <= '0;
      lead_len   <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (step) begin
      cur_len   <= (bit_now && !close) ? run_len : '0;
      cur_start <= run_start;
      if (close && is_lead)
        lead_len <= run_len;
      if (take) begin
        best_start <= run_start;
        best_len   <= cand_len;
      end
    end
  end

  // R3
  bestlen_range_chk: assert property (@(posedge clk) disable iff (rst)
    best_len <= LW'(NPH));

  // R4
  best_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && $past(!clr)) |-> (best_len >= $past(best_len)));
endmodule

// File: rtl/phsel_pick.sv
// Three-quarter position inside the chosen window, wrapped onto the ring.
module phsel_pick #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1)
) (
  input  logic [PW-1:0] win_start,
  input  logic [LW-1:0] win_len,
  output logic [PW-1:0] pick
);
  logic [LW+1:0] prod, pos;

  always_comb begin
    prod = {2'b00, win_len} * (LW + 2)'(3);
    pos  = prod >> 2;
    if (pos != '0)
      pos = pos - (LW + 2)'(1);
    pick = win_start + pos[PW-1:0];
  end
endmodule

// File: rtl/phase_window_sel.sv
module phase_window_sel #(
  parameter int NPH = 16,
  localparam int PW = $clog2(NPH),
  localparam int LW = $clog2(NPH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NPH-1:0] pass_mask,
  output logic [PW-1:0]  sel_phase,
  output logic           res_valid,
  output logic           res_err
);
  import phsel_pkg::*;

  sel_state_t     state;
  logic [PW-1:0]  idx;
  logic [NPH-1:0] mask_q;
  logic           wrap_q;
  logic           accept, step;
  logic [PW-1:0]  best_start, pick;
  logic [LW-1:0]  best_len;

  assign accept = (state == ST_IDLE) && start;
  assign step   = (state == ST_SCAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      mask_q    <= '0;
      wrap_q    <= 1'b0;
      sel_phase <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          mask_q <= pass_mask;
          wrap_q <= pass_mask[0] && pass_mask[NPH-1] && !(&pass_mask);
          idx    <= '0;
          state  <= ST_SCAN;
        end
        ST_SCAN: begin
          idx <= idx + PW'(1);
          if (idx == PW'(NPH - 1))
            state <= ST_DONE;
        end
        ST_DONE: begin
          state <= ST_IDLE;
          if (best_len == '0) begin
            res_err <= 1'b1;
          end else begin
            res_valid <= 1'b1;
            sel_phase <= pick;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  phsel_scan #(.NPH(NPH)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .clr        (accept),
    .step       (step),
    .idx        (idx),
    .mask       (mask_q),
    .wrap       (wrap_q),
    .best_start (best_start),
    .best_len   (best_len)
  );

  phsel_pick #(.NPH(NPH)) u_pick (
    .win_start (best_start),
    .win_len   (best_len),
    .pick      (pick)
  );

  // R8
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_err));

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid || res_err) |=> !(res_valid || res_err));

  // R2
  zero_mask_err_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && mask_q == '0) |=> res_err);

  // R10
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (sel_phase == $past(sel_phase)));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SCAN) |=> (mask_q == $past(mask_q)));

  // R8
  scan_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SCAN && idx != PW'(NPH - 1)) |=>
      (state == ST_SCAN && idx == $past(idx) + PW'(1)));
endmodule

// File: tb/tb_phase_window_sel.sv
module tb_phase_window_sel;
  localparam int NPH = 16;
  localparam int PW  = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [NPH-1:0] pass_mask = '0;
  logic [PW-1:0]  sel_phase;
  logic           res_valid, res_err;

  int total = 0;
  int bad = 0;
  int last_phase = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  phase_window_sel #(.NPH(NPH)) dut (
    .clk(clk), .rst(rst), .start(start), .pass_mask(pass_mask),
    .sel_phase(sel_phase), .res_valid(res_valid), .res_err(res_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns {err, phase}; list-of-runs model
  function automatic logic [4:0] model(input logic [15:0] m);
    int st[16];
    int ln[16];
    int nr = 0, bl = 0, bs = 0, p;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (i == 0 || !m[i-1]) begin
          st[nr] = i; ln[nr] = 0; nr++;
        end
        ln[nr-1]++;
      end
    end
    if (nr == 0) return 5'b10000;
    if (nr > 1 && st[0] == 0 && st[nr-1] + ln[nr-1] == 16) begin
      ln[nr-1] += ln[0];
      ln[0] = 0;
    end
    for (int r = 0; r < nr; r++)
      if (ln[r] > bl) begin bl = ln[r]; bs = st[r]; end
    p = (bl * 3) / 4;
    if (p != 0) p--;
    return {1'b0, 4'((bs + p) % 16)};
  endfunction

  task automatic judge(input logic [15:0] m, input int lat, input string req);
    logic [4:0] e;
    e = model(m);
    chk(lat == NPH + 1, "R8 latency", lat, NPH + 1);
    if (e[4]) begin
      chk(res_err && !res_valid, "R2 error pulse", {res_err, res_valid}, 2);
      chk(int'(sel_phase) == last_phase, "R10 hold on error", sel_phase, last_phase);
    end else begin
      chk(res_valid && !res_err, {req, " valid pulse"}, {res_valid, res_err}, 2);
      chk(int'(sel_phase) == int'(e[3:0]), {req, " phase"}, sel_phase, e[3:0]);
      last_phase = e[3:0];
    end
  endtask

  task automatic wait_res(output int lat);
    lat = 0;
    while (!(res_valid || res_err) && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run(input logic [15:0] m, input string req);
    int lat;
    @(negedge clk);
    pass_mask = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pass_mask = ~m;
    wait_res(lat);
    judge(m, lat, req);
    @(negedge clk);
    chk(!res_valid && !res_err, "R8 single-cycle pulse", {res_valid, res_err}, 0);
  endtask

  initial begin
    while (!finished && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!res_valid && !res_err && sel_phase == 0, "R1 reset state",
        {res_valid, res_err, sel_phase}, 0);

    run(16'h0000, "R2");                 // error, phase stays 0
    run(16'hFFFF, "R6");                 // single window, phase 11
    chk(sel_phase == 4'd11, "R6 all ones", sel_phase, 11);
    run(16'h00F0, "R3");                 // run 4..7 -> phase 6
    chk(sel_phase == 4'd6, "R7 position", sel_phase, 6);
    run(16'h0F0F, "R4");                 // tie, earliest -> 2
    chk(sel_phase == 4'd2, "R4 tie earliest", sel_phase, 2);
    run(16'h8001, "R5");                 // 15+0 -> phase 15
    chk(sel_phase == 4'd15, "R5 wrap pair", sel_phase, 15);
    run(16'hC007, "R5");                 // 14,15,0,1,2 -> phase 0
    chk(sel_phase == 4'd0, "R5 wrap join", sel_phase, 0);
    run(16'hC071, "R5");                 // joined len3 ties 4..6 -> 5
    chk(sel_phase == 4'd5, "R5 wrap tie ranks late", sel_phase, 5);
    run(16'h0000, "R10");
    chk(sel_phase == 4'd5, "R10 held through error", sel_phase, 5);

    // R9: start held high, mask changed mid-run, completion meets start
    @(negedge clk);
    pass_mask = 16'h0E00;                // run 9..11 -> phase 10
    start = 1'b1;
    @(negedge clk);
    pass_mask = 16'h0003;                // 0,1 -> phase 0
    wait_res(lat);
    judge(16'h0E00, lat, "R9 captured mask");
    @(negedge clk);                      // next accept happened here
    chk(!res_valid && !res_err, "R9 no double pulse", {res_valid, res_err}, 0);
    start = 1'b0;
    pass_mask = 16'hFFFF;
    wait_res(lat);
    judge(16'h0003, lat, "R9 second run");

    // strided sweep across the mask space
    for (int k = 0; k < 65536; k += 11)
      run(16'(k), "R7 sweep");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule